// File: doc/BRIEF.md
# GPIO Port Register Controller

This block controls one eight-pin general-purpose I/O port from a small memory-mapped register bus. Software writes an output value, can flip individual output bits with write-one set and clear aliases, chooses a four-bit mode for each pin, and picks which pins may raise a wake request. The block returns the synchronized pin levels through an input register.

Each pin's output goes through a multiplexer. In normal output mode the pin drives its output-register bit. In alternate mode the pin drives a timer output or a serial-controller output, and the timer wins when it is both mapped and enabled. A pin with no peripheral mapped drives 0. The block also produces one output-enable per pin. It raises a wake request when a watched pin's synchronized level changes.

Bus reads are combinational from `busAddr`. Writes take effect on the rising clock edge while `busEn` and `busWe` are high.

Top module: `gpio_port_ctrl_top`

## Requirements
- R1: After reset, the following hold:
  - the output register and wake mask are 0;
  - both config words read 0x4444, so every pin is in digital-input mode;
  - `padOe`, `padOut` and `wakeReq` are 0.
- R2: A write to word 1 loads the output register from `busWdata[7:0]`. Reading word 1 returns it zero-extended.
- R3: A write to word 2 clears each output-register bit whose write-data bit is 1 and leaves the others unchanged. Word 2 reads as 0.
- R4: A write to word 3 sets each output-register bit whose write-data bit is 1 and leaves the others unchanged. Word 3 reads as 0.
- R5: Word 5 holds the modes of pins 3..0, with pin n at bits [4n+3:4n]. Word 6 holds the modes of pins 7..4, with pin n at bits [4(n-4)+3:4(n-4)]. Both words are read/write.
- R6: Word 0 returns each pin's level after a two-flop synchronizer, so a change on `padIn` appears two clock edges later. A pin in analog mode (code 0x0) reads 0.
- R7: In mode 0x1 the pin has `padOe`=1 and `padOut` equal to its output-register bit.
- R8: In mode 0x9 the pin has `padOe`=1, and `padOut` is chosen as follows:
  - `tmrOut` when both `tmrMap` and `tmrEn` are 1 for that pin;
  - otherwise `serOut` when `serMap` is 1;
  - otherwise 0.
- R9: In mode 0x0, and in every code other than 0x1 and 0x9, the pin has `padOe`=0 and `padOut`=0.
- R10: Word 4 is the wake mask. `wakeReq` is 1 in a cycle exactly when a masked pin's synchronized level differs from its synchronized level one cycle earlier.
- R11: The following have no effect on any register:
  - word 7 reads as 0;
  - writes to word 0 or word 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Bus access valid |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register word index |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` (combinational) |
| padIn | input | 8 | Raw pin levels |
| padOut | output | 8 | Pin output levels |
| padOe | output | 8 | Pin output enables |
| tmrMap | input | 8 | Timer output mapped to pin |
| tmrEn | input | 8 | Timer output enabled |
| tmrOut | input | 8 | Timer alternate output |
| serMap | input | 8 | Serial output mapped to pin |
| serOut | input | 8 | Serial alternate output |
| wakeReq | output | 1 | Wake request |

## Verification
A corrupted output-register bit shows on `padOut` of any pin in mode 0x1 in the very next cycle, and on a read of word 1. A wrong mode field changes `padOe` for that pin in the same cycle, since the mux is combinational. A wrong synchronizer or previous-level flop shows as a `wakeReq` pulse that is missing, extra or one cycle late, and as a word-0 value off by a cycle. The bench therefore compares every pin output, the wake line and each read on every clock against a behavioural model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 3;

  localparam logic [MODE_W-1:0] MODE_ANALOG = 4'h0;
  localparam logic [MODE_W-1:0] MODE_OUTPUT = 4'h1;
  localparam logic [MODE_W-1:0] MODE_INPUT  = 4'h4;
  localparam logic [MODE_W-1:0] MODE_ALT    = 4'h9;

  localparam logic [ADDR_W-1:0] ADR_IN    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OUT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SET   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_WAKE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CFGLO = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CFGHI = 3'd6;

  typedef struct packed {
    logic wrOut;
    logic wrClr;
    logic wrSet;
    logic wrWake;
    logic wrCfgLo;
    logic wrCfgHi;
  } regStrobe_t;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
(
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);
  always_comb begin
    strb = '0;
    if (busEn && busWe) begin
      case (busAddr)
        ADR_OUT:   strb.wrOut   = 1'b1;
        ADR_CLR:   strb.wrClr   = 1'b1;
        ADR_SET:   strb.wrSet   = 1'b1;
        ADR_WAKE:  strb.wrWake  = 1'b1;
        ADR_CFGLO: strb.wrCfgLo = 1'b1;
        ADR_CFGHI: strb.wrCfgHi = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter  int PINS  = 8,
  localparam int HALF  = PINS / 2,
  localparam int CFG_W = HALF * MODE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic [CFG_W-1:0]       wrData,
  input  logic [PINS-1:0]        padIn,
  output logic [CFG_W-1:0]       rdData,
  output logic [PINS-1:0]        outReg,
  output logic [PINS*MODE_W-1:0] cfgAll,
  output logic                   wakeReq
);
  logic [PINS-1:0] wakeMask;
  logic [PINS-1:0] syncA, syncB, prevB;
  logic [PINS-1:0] isAnalog;
  logic [PINS-1:0] inLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      wakeMask <= '0;
      cfgAll   <= {PINS{MODE_INPUT}};
    end else begin
      if (strb.wrOut)   outReg <= wrData[PINS-1:0];
      if (strb.wrClr)   outReg <= outReg & ~wrData[PINS-1:0];
      if (strb.wrSet)   outReg <= outReg | wrData[PINS-1:0];
      if (strb.wrWake)  wakeMask <= wrData[PINS-1:0];
      if (strb.wrCfgLo) cfgAll[CFG_W-1:0] <= wrData;
      if (strb.wrCfgHi) cfgAll[2*CFG_W-1:CFG_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_analog
    assign isAnalog[g] = (cfgAll[g*MODE_W +: MODE_W] == MODE_ANALOG);
  end

  assign inLevel = syncB & ~isAnalog;
  assign wakeReq = |((syncB ^ prevB) & wakeMask);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_IN:    rdData[PINS-1:0] = inLevel;
      ADR_OUT:   rdData[PINS-1:0] = outReg;
      ADR_WAKE:  rdData[PINS-1:0] = wakeMask;
      ADR_CFGLO: rdData = cfgAll[CFG_W-1:0];
      ADR_CFGHI: rdData = cfgAll[2*CFG_W-1:CFG_W];
      default:   rdData = '0;
    endcase
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.wrClr, strb.wrSet, strb.wrWake, strb.wrCfgLo, strb.wrCfgHi})); // R11
  AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((outReg & $past(wrData[PINS-1:0])) == '0)); // R3
  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((outReg & $past(wrData[PINS-1:0])) == $past(wrData[PINS-1:0]))); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrOut || strb.wrClr || strb.wrSet) |=> $stable(outReg)); // R2
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PINS*MODE_W-1:0] cfgAll,
  input  logic [PINS-1:0]        outReg,
  input  logic [PINS-1:0]        tmrMap,
  input  logic [PINS-1:0]        tmrEn,
  input  logic [PINS-1:0]        tmrOut,
  input  logic [PINS-1:0]        serMap,
  input  logic [PINS-1:0]        serOut,
  output logic [PINS-1:0]        padOut,
  output logic [PINS-1:0]        padOe
);
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [MODE_W-1:0] pinMode;
    logic              altBit;

    assign pinMode = cfgAll[g*MODE_W +: MODE_W];
    assign altBit  = (tmrMap[g] && tmrEn[g]) ? tmrOut[g]
                   : (serMap[g] ? serOut[g] : 1'b0);

    always_comb begin
      case (pinMode)
        MODE_OUTPUT: begin padOut[g] = outReg[g]; padOe[g] = 1'b1; end
        MODE_ALT:    begin padOut[g] = altBit;    padOe[g] = 1'b1; end
        default:     begin padOut[g] = 1'b0;      padOe[g] = 1'b0; end
      endcase
    end

    AST_TMR_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
      (pinMode == MODE_ALT && tmrMap[g] && tmrEn[g]) |-> (padOut[g] == tmrOut[g])); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (pinMode == MODE_ALT && !(tmrMap[g] && tmrEn[g]) && !serMap[g]) |-> !padOut[g]); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !padOe[g] |-> !padOut[g]); // R9
  end
endmodule

// File: rtl/gpio_port_ctrl_top.sv
module gpio_port_ctrl_top
  import gpio_port_pkg::*;
#(
  parameter  int PINS   = 8,
  localparam int DATA_W = (PINS / 2) * MODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  input  logic [PINS-1:0]   tmrMap,
  input  logic [PINS-1:0]   tmrEn,
  input  logic [PINS-1:0]   tmrOut,
  input  logic [PINS-1:0]   serMap,
  input  logic [PINS-1:0]   serOut,
  output logic              wakeReq
);
  regStrobe_t             strb;
  logic [PINS-1:0]        outReg;
  logic [PINS*MODE_W-1:0] cfgAll;

  gpio_port_decode decode_i (
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr), .strb(strb)
  );

  gpio_port_regs #(.PINS(PINS)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(busAddr), .wrData(busWdata),
    .padIn(padIn), .rdData(busRdata), .outReg(outReg), .cfgAll(cfgAll),
    .wakeReq(wakeReq)
  );

  gpio_port_mux #(.PINS(PINS)) mux_i (
    .clk(clk), .rstN(rstN), .cfgAll(cfgAll), .outReg(outReg),
    .tmrMap(tmrMap), .tmrEn(tmrEn), .tmrOut(tmrOut),
    .serMap(serMap), .serOut(serOut), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/gpio_port_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  padIn = '0, tmrMap = '0, tmrEn = '0, tmrOut = '0, serMap = '0, serOut = '0;
  logic [7:0]  padOut, padOe;
  logic        wakeReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .tmrMap(tmrMap), .tmrEn(tmrEn), .tmrOut(tmrOut),
    .serMap(serMap), .serOut(serOut), .wakeReq(wakeReq)
  );

  // Behavioural reference model
  logic [7:0]  mOut, mWake, lvlQ1, lvlQ2, lvlQ3;
  logic [31:0] mCfg;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOut <= 0; mWake <= 0; mCfg <= 32'h4444_4444;
      lvlQ1 <= 0; lvlQ2 <= 0; lvlQ3 <= 0;
    end else begin
      if (busEn && busWe) begin
        case (busAddr)
          3'd1: mOut <= busWdata[7:0];
          3'd2: mOut <= mOut & ~busWdata[7:0];
          3'd3: mOut <= mOut | busWdata[7:0];
          3'd4: mWake <= busWdata[7:0];
          3'd5: mCfg[15:0] <= busWdata;
          3'd6: mCfg[31:16] <= busWdata;
          default: ;
        endcase
      end
      lvlQ1 <= padIn; lvlQ2 <= lvlQ1; lvlQ3 <= lvlQ2;
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [2:0] a);
    logic [7:0] lv;
    for (int p = 0; p < 8; p++) lv[p] = (mCfg[4*p +: 4] == 4'h0) ? 1'b0 : lvlQ2[p];
    case (a)
      3'd0: return {8'h0, lv};
      3'd1: return {8'h0, mOut};
      3'd4: return {8'h0, mWake};
      3'd5: return mCfg[15:0];
      3'd6: return mCfg[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R10";
      3'd5, 3'd6: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic compareAll();
    if (!rstN) return;
    for (int p = 0; p < 8; p++) begin
      logic [3:0] m;
      logic eOe, eOut;
      string tag;
      m = mCfg[4*p +: 4];
      eOe = (m == 4'h1) || (m == 4'h9);
      if (m == 4'h1) begin eOut = mOut[p]; tag = "R7"; end
      else if (m == 4'h9) begin
        eOut = (tmrMap[p] && tmrEn[p]) ? tmrOut[p] : (serMap[p] ? serOut[p] : 1'b0);
        tag = "R8";
      end else begin eOut = 1'b0; tag = "R9"; end
      chk(tag, $sformatf("padOe[%0d]", p), {15'h0, padOe[p]}, {15'h0, eOe});
      chk(tag, $sformatf("padOut[%0d]", p), {15'h0, padOut[p]}, {15'h0, eOut});
    end
    chk("R10", "wakeReq", {15'h0, wakeReq}, {15'h0, |((lvlQ2 ^ lvlQ3) & mWake)});
    if (busEn && !busWe)
      chk(readTag(busAddr), $sformatf("busRdata@%0d", busAddr), busRdata, expRead(busAddr));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic busWr(input logic [2:0] a, input logic [15:0] d);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d;
    tick();
    busEn = 0; busWe = 0;
  endtask

  task automatic busRd(input logic [2:0] a);
    busEn = 1; busWe = 0; busAddr = a;
    tick();
    busEn = 0;
  endtask

  function automatic logic [15:0] randCfg();
    logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h4, 4'h9, 4'h2, 4'hF};
    logic [15:0] v;
    for (int f = 0; f < 4; f++) v[4*f +: 4] = codes[$urandom % 6];
    return v;
  endfunction

  task automatic randPeriph();
    tmrMap = 8'($urandom); tmrEn = 8'($urandom); tmrOut = 8'($urandom);
    serMap = 8'($urandom); serOut = 8'($urandom);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state seen at the ports while reset is held
    repeat (2) @(negedge clk);
    chk("R1", "padOe", {8'h0, padOe}, 16'h0);
    chk("R1", "padOut", {8'h0, padOut}, 16'h0);
    chk("R1", "wakeReq", {15'h0, wakeReq}, 16'h0);
    busAddr = 3'd5; #1 chk("R1", "cfgLo", busRdata, 16'h4444);
    busAddr = 3'd6; #1 chk("R1", "cfgHi", busRdata, 16'h4444);
    busAddr = 3'd1; #1 chk("R1", "outReg", busRdata, 16'h0);
    busAddr = 3'd4; #1 chk("R1", "wakeMask", busRdata, 16'h0);
    busAddr = 3'd0;
    @(negedge clk);
    rstN = 1;
    tick();

    // R2 R3 R4 R7: normal output mode
    busWr(3'd5, 16'h1111); busWr(3'd6, 16'h1111);
    busWr(3'd1, 16'hFFA5); busRd(3'd1);
    busWr(3'd2, 16'h000F); busRd(3'd1); busRd(3'd2);
    busWr(3'd3, 16'h0030); busRd(3'd1); busRd(3'd3);
    busWr(3'd2, 16'h0000); busWr(3'd3, 16'h0000); busRd(3'd1);

    // R8: alternate mode with all peripheral combinations
    busWr(3'd5, 16'h9999); busWr(3'd6, 16'h9999);
    for (int i = 0; i < 60; i++) begin randPeriph(); tick(); end

    // R5 R9: mixed modes including other codes
    busWr(3'd5, 16'h0914); busWr(3'd6, 16'hF219);
    busRd(3'd5); busRd(3'd6);
    for (int i = 0; i < 20; i++) begin randPeriph(); tick(); end

    // R6 R10: synchronizer, analog masking and wake detection
    busWr(3'd4, 16'h003C);
    busEn = 1; busWe = 0; busAddr = 3'd0;
    for (int i = 0; i < 120; i++) begin
      if ((i % 3) == 0) padIn = 8'($urandom);
      tick();
    end
    busEn = 0;

    // R11: ignored addresses
    busWr(3'd0, 16'hFFFF); busWr(3'd7, 16'hFFFF); busRd(3'd7); busRd(3'd1);

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom % 4;
      padIn = 8'($urandom);
      randPeriph();
      if (kind == 0) busWr(3'($urandom), ($urandom % 2) ? randCfg() : 16'($urandom));
      else if (kind == 1) busRd(3'($urandom));
      else tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule